// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a compare-match timer. It has an up-counter that advances once per prescaled tick, a compare register, and a control/status register. The control/status register holds a sticky match flag, an interrupt enable and a clock-select field. When the counter reaches the compare value, the next tick returns the counter to zero and raises the flag. The interrupt line stays high while both the flag and the enable are set. The channel counts only while its own bit in a start register is 1. That start register is shared between channels, so every other bit of it is stored and read back untouched.

Counter writes model a crossing into a slow counting domain. The written value is held pending and is loaded on the second prescaled tick after the write, so reads return the old count until then. A small write-sync state machine tracks this with three states:
- `WS_IDLE`: nothing pending.
- `WS_ARMED`: a value is waiting for its first tick.
- `WS_READY`: the first tick has passed.

Its transitions are:
- load: any state goes to `WS_ARMED` on a counter write, so a fresh write restarts the wait.
- first tick: `WS_ARMED` goes to `WS_READY`.
- apply: `WS_READY` goes to `WS_IDLE` on the next tick, and the pending value is written into the counter.

Parameter `WIDE` selects the variant. `WIDE=1` (default) gives a 32-bit counter with register index times 4 as byte address. `WIDE=0` gives a 16-bit counter with register index times 2.

Top module: `cmt_channel`

## Requirements
- R1: After reset the start register, control/status and counter read 0, the compare register reads all ones, and `irq` is 0.
- R2: Register index = byte address / 4 (`WIDE=1`). The indices are: start = 0, control/status = 1, counter = 2, compare = 3. A compare write is read back at index 3 and leaves the counter unchanged.
- R3: The counter advances only while bit `CH_BIT` (default 2) of the start register is 1. All start-register bits are stored and read back as written. Writes to the other registers leave the start register unchanged.
- R4: Control/status bits [1:0] select the tick divider: 0→8, 1→32, 2→128, 3→512 clock cycles per tick.
- R5: On a tick with the channel running and the counter equal to the compare value, the counter returns to 0 and the match flag (bit 15; bit 7 when `WIDE=0`) sets. Consecutive matches are (compare+1)×divider clocks apart.
- R6: Writing 0 at a status bit clears it, and writing 1 leaves it unchanged. Writing 0 to the whole control/status register clears the enable, the select field and both status bits.
- R7: `irq` is high exactly when the match flag and the interrupt enable (bit 5; bit 6 when `WIDE=0`) are both 1.
- R8: A counter write is loaded on the second tick after the write. Before that tick, reads return the previous (still counting) value.
- R9: A second counter write before the pending one is loaded replaces it and restarts the two-tick wait.
- R10: When a pending counter value is loaded on a tick that also matches, the loaded value wins over the clear to zero, and the match flag still sets.
- R11 (`WIDE=1`): status bit 14 sets when a match occurs while the match flag is already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; ticks are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register addressed by `addr` |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt: match flag qualified by enable |

## Verification
On every cycle, assertions check the following:
- the counter holds between ticks and while the channel is stopped;
- a running match tick without a pending load wraps the counter to zero;
- a write of 0 to the flag bit clears it unless a match coincides;
- non-start writes never disturb the shared start register;
- each counter write arms the sync machine.

Only the bench scenarios can show the rest: the exact period for each compare value and divider, the tick on which a pending write lands, a restarted wait, and load-over-clear priority on a matching tick.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int PRE_W = 10;

    localparam logic [1:0] IDX_START = 2'd0;
    localparam logic [1:0] IDX_CTRL  = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;
    localparam logic [1:0] IDX_CMP   = 2'd3;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_READY = 2'd2
    } wsync_e;

    // Last prescaler count before a tick: divider 8 << (2*sel), minus one
    function automatic logic [PRE_W-1:0] tick_limit(input logic [1:0] sel);
        logic [PRE_W-1:0] d;
        d = PRE_W'(8) << {sel, 1'b0};
        return d - PRE_W'(1);
    endfunction
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = tick_limit(sel);
        tick = (pre_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // R4
    // tick_space_chk
    property p_tick_space;
        @(posedge clk) disable iff (!rst_n) tick |=> !tick;
    endproperty
    tick_space_chk: assert property (p_tick_space);
endmodule

// File: rtl/cmt_wsync.sv
module cmt_wsync
    import cmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         apply,
    output logic [W-1:0] apply_val
);
    wsync_e       state_q, state_d;
    logic [W-1:0] pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (load) state_d = WS_ARMED;
            WS_ARMED: if (load) state_d = WS_ARMED;
                      else if (tick) state_d = WS_READY;
            WS_READY: if (load) state_d = WS_ARMED;
                      else if (tick) state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) pend_q <= load_val;
        end
    end

    always_comb begin
        apply     = tick && (state_q == WS_READY) && !load;
        apply_val = pend_q;
    end

    // R9
    // arm_on_load_chk
    property p_arm_on_load;
        @(posedge clk) disable iff (!rst_n) load |=> (state_q == WS_ARMED);
    endproperty
    arm_on_load_chk: assert property (p_arm_on_load);
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] cmp,
    input  logic         apply,
    input  logic [W-1:0] apply_val,
    output logic [W-1:0] cnt,
    output logic         match
);
    always_comb match = tick && run && (cnt == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (apply)
            cnt <= apply_val;
        else if (match)
            cnt <= '0;
        else if (tick && run)
            cnt <= cnt + W'(1);
    end

    // R4
    // idle_hold_chk
    property p_idle_hold;
        @(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt);
    endproperty
    idle_hold_chk: assert property (p_idle_hold);

    // R3
    // halt_hold_chk
    property p_halt_hold;
        @(posedge clk) disable iff (!rst_n) (tick && !run && !apply) |=> $stable(cnt);
    endproperty
    halt_hold_chk: assert property (p_halt_hold);

    // R5
    // wrap_zero_chk
    property p_wrap_zero;
        @(posedge clk) disable iff (!rst_n)
            (tick && run && !apply && (cnt == cmp)) |=> (cnt == '0);
    endproperty
    wrap_zero_chk: assert property (p_wrap_zero);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int WIDE   = 1,
    parameter int CH_BIT = 2,
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    localparam int CW     = (WIDE != 0) ? 32 : 16;
    localparam int FLAG_B = (WIDE != 0) ? 15 : 7;
    localparam int IE_B   = (WIDE != 0) ? 5 : 6;
    localparam int OVR_B  = 14;
    localparam int IDX_LO = (WIDE != 0) ? 2 : 1;

    logic [1:0]    idx;
    logic          wr_start, wr_ctrl, wr_count, wr_cmp;
    logic [CW-1:0] start_q, cmp_q, cnt;
    logic [1:0]    cks_q;
    logic          ie_q, flag_q, ovr_q;
    logic          tick, match, apply, run;
    logic [CW-1:0] apply_val;

    always_comb begin
        idx      = addr[IDX_LO +: 2];
        wr_start = wr_en && (idx == IDX_START);
        wr_ctrl  = wr_en && (idx == IDX_CTRL);
        wr_count = wr_en && (idx == IDX_COUNT);
        wr_cmp   = wr_en && (idx == IDX_CMP);
        run      = start_q[CH_BIT];
    end

    cmt_prescale u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (cks_q),
        .tick (tick)
    );

    cmt_wsync #(.W(CW)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (wr_count),
        .load_val (wdata[CW-1:0]),
        .apply    (apply),
        .apply_val(apply_val)
    );

    cmt_counter #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .cmp      (cmp_q),
        .apply    (apply),
        .apply_val(apply_val),
        .cnt      (cnt),
        .match    (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cmp_q   <= '1;
            cks_q   <= '0;
            ie_q    <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (wr_start) start_q <= wdata[CW-1:0];
            if (wr_cmp)   cmp_q   <= wdata[CW-1:0];
            if (wr_ctrl) begin
                cks_q <= wdata[1:0];
                ie_q  <= wdata[IE_B];
            end
            if (match)
                flag_q <= 1'b1;
            else if (wr_ctrl)
                flag_q <= flag_q & wdata[FLAG_B];
        end
    end

    generate
        if (WIDE != 0) begin : g_ovr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ovr_q <= 1'b0;
                else if (match && flag_q)
                    ovr_q <= 1'b1;
                else if (wr_ctrl)
                    ovr_q <= ovr_q & wdata[OVR_B];
            end
        end else begin : g_no_ovr
            always_comb ovr_q = 1'b0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_START: rdata = BUS_W'(start_q);
            IDX_CTRL: begin
                rdata[1:0]    = cks_q;
                rdata[IE_B]   = ie_q;
                rdata[FLAG_B] = flag_q;
                if (WIDE != 0) rdata[OVR_B] = ovr_q;
            end
            IDX_COUNT: rdata = BUS_W'(cnt);
            IDX_CMP:   rdata = BUS_W'(cmp_q);
            default:   rdata = '0;
        endcase
        irq = flag_q & ie_q;
    end

    // R3
    // start_keep_chk
    property p_start_keep;
        @(posedge clk) disable iff (!rst_n) (wr_en && (idx != IDX_START)) |=> $stable(start_q);
    endproperty
    start_keep_chk: assert property (p_start_keep);

    // R6
    // flag_clear_chk
    property p_flag_clear;
        @(posedge clk) disable iff (!rst_n) (wr_ctrl && !wdata[FLAG_B] && !match) |=> !flag_q;
    endproperty
    flag_clear_chk: assert property (p_flag_clear);

    // R5
    // flag_set_chk
    property p_flag_set;
        @(posedge clk) disable iff (!rst_n) match |=> flag_q;
    endproperty
    flag_set_chk: assert property (p_flag_set);
endmodule

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;
    localparam int LIMIT = 150000;
    localparam int RUNB  = 32'h4;
    localparam int IE    = 32'h20;
    localparam int FLG   = 32'h8000;
    localparam int OVR   = 32'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    cmt_channel u_cmt_channel (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > LIMIT) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: all requirements, actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        addr = 4'(idx * 4);
        #1;
        v = rdata;
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        addr  = 4'(idx * 4);
        wdata = v;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    // returns at the negedge just after a counting tick, with the new count
    task automatic sync_tick(output logic [31:0] c0);
        logic [31:0] a, b;
        rd(2, a);
        forever begin
            @(negedge clk);
            rd(2, b);
            if (b != a) break;
            a = b;
        end
        c0 = b;
    endtask

    task automatic measure(input int cmp, input int sel);
        int div, t1, t2;
        div = 8 << (2 * sel);
        wr(0, 0);
        wr(1, IE | sel);
        wr(3, cmp);
        wr(2, 0);
        repeat (2 * div + 4) @(negedge clk);
        wr(1, IE | sel);
        wr(0, RUNB);
        wait_irq();
        t1 = cyc;
        wr(1, IE | sel);
        wait_irq();
        t2 = cyc;
        // R5 period, R4 divider select
        chk($sformatf("R5/R4 period cmp=%0d sel=%0d", cmp, sel), 32'(t2 - t1), 32'((cmp + 1) * div));
        wr(0, 0);
    endtask

    initial begin
        logic [31:0] v, c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); chk("R1 start reg", v, 32'h0);
        rd(1, v); chk("R1 ctrl reg", v, 32'h0);
        rd(2, v); chk("R1 counter", v, 32'h0);
        rd(3, v); chk("R1 compare", v, 32'hFFFF_FFFF);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 address map
        wr(3, 32'h1234);
        rd(3, v); chk("R2 compare readback", v, 32'h1234);
        rd(2, v); chk("R2 counter untouched", v, 32'h0);

        // R3 shared start register
        wr(0, 32'h5A5A_A5A0);
        rd(0, v); chk("R3 start readback", v, 32'h5A5A_A5A0);
        wr(1, 32'h0);
        wr(3, 32'hFFFF_FFFF);
        rd(0, v); chk("R3 start kept", v, 32'h5A5A_A5A0);
        repeat (40) @(negedge clk);
        rd(2, v); chk("R3 stopped counter", v, 32'h0);
        wr(0, 32'h5A5A_A5A4);
        repeat (40) @(negedge clk);
        rd(2, v); chk("R3 running counter advanced", 32'(v != 0), 32'h1);
        wr(0, 32'h5A5A_A5A0);
        rd(2, c0);
        repeat (40) @(negedge clk);
        rd(2, v); chk("R3 counter held after stop", v, c0);
        rd(0, v); chk("R3 other bits preserved", v, 32'h5A5A_A5A0);

        // R4 R5 sweep
        for (int c = 0; c < 9; c++) measure(c, 0);
        for (int s = 1; s < 4; s++) measure(3, s);

        // R7 R11 R6 flag behaviour
        wr(0, 0);
        wr(1, IE);
        wr(3, 3);
        wr(2, 0);
        repeat (20) @(negedge clk);
        wr(1, IE);
        wr(0, RUNB);
        wait_irq();
        repeat (40) @(negedge clk);
        wr(0, 0);
        rd(1, v); chk("R11 second status set", v, FLG | OVR | IE);
        chk("R7 irq with flag and enable", 32'(irq), 32'h1);
        wr(1, FLG | IE);
        rd(1, v); chk("R6 write 1 keeps flag, R11 cleared", v, FLG | IE);
        wr(1, FLG);
        rd(1, v); chk("R6 flag kept with enable off", v, FLG);
        chk("R7 irq low when disabled", 32'(irq), 32'h0);
        wr(1, IE);
        rd(1, v); chk("R6 flag cleared", v, IE);
        chk("R7 irq low after clear", 32'(irq), 32'h0);

        // R8 write latency
        wr(3, 32'hFFFF_FFFF);
        wr(2, 0);
        repeat (20) @(negedge clk);
        wr(0, RUNB);
        repeat (20) @(negedge clk);
        sync_tick(c0);
        @(negedge clk);
        wr(2, 32'h1000);
        repeat (5) @(negedge clk);
        rd(2, v); chk("R8 old value before first tick", v, c0);
        @(negedge clk);
        rd(2, v); chk("R8 old value counts on first tick", v, c0 + 1);
        repeat (7) @(negedge clk);
        rd(2, v); chk("R8 old value before second tick", v, c0 + 1);
        @(negedge clk);
        rd(2, v); chk("R8 loaded on second tick", v, 32'h1000);

        // R9 restart
        sync_tick(c0);
        @(negedge clk);
        wr(2, 32'h2000);
        repeat (7) @(negedge clk);
        wr(2, 32'h3000);
        repeat (6) @(negedge clk);
        rd(2, v); chk("R9 no load after restart", v, c0 + 2);
        repeat (8) @(negedge clk);
        rd(2, v); chk("R9 second value loaded", v, 32'h3000);

        // R10 load beats match clear
        wr(1, IE);
        sync_tick(c0);
        wr(3, c0 + 1);
        wr(2, 32'h100);
        repeat (14) @(negedge clk);
        rd(2, v); chk("R10 loaded value wins", v, 32'h100);
        rd(1, v); chk("R10 flag set on match", v, FLG | IE);
        wr(0, 0);

        // R6 whole-register zero write
        wr(1, 0);
        rd(1, v); chk("R6 zero write clears ctrl", v, 32'h0);
        chk("R6 irq low after zero write", 32'(irq), 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule